// File: doc/BRIEF.md
# Light Sensor Interrupt Generator

This block watches a stream of light-sensor conversion results and decides when to raise an interrupt. Each time a new set of four 20-bit channel results (infrared, green, red, blue) is strobed in, the block picks one channel and tests it against the programmed rule. The interrupt is driven as an open-drain, active-low pin. In this model the pin is an output-enable that pulls the line low while the interrupt is active.

Two rules are available. In window mode, a result is an event when it lies outside the band set by a lower and an upper bound. In variance mode, a result is an event when it moved too far from the result before it, and a 3-bit code selects the allowed step. A persistence setting asks for a run of consecutive events before the interrupt fires. Once the interrupt fires it stays set until a status-read strobe clears it.

Top module: `lsint_gen`

## Requirements
- R1: `src_sel` picks the evaluated channel: 2'b00 infrared, 2'b01 green, 2'b10 red, 2'b11 blue.
- R2: With `var_mode`=0, a result is an event when it is strictly greater than `thr_hi` or strictly less than `thr_lo`. A result equal to either bound is not an event.
- R3: With `var_mode`=1, a result is an event when |current − previous| is strictly greater than 8·2^`var_code` counts (code 0 gives 8, code 3 gives 64, code 7 gives 1024).
- R4: With persistence value P on `persist`, the interrupt sets on the (P+1)-th consecutive event. Any evaluated non-event resets the run to zero. While events continue past that point, each further event sets the interrupt again.
- R5: `int_flag` stays at 1 until a cycle with `status_rd`=1, after which it reads 0.
- R6: When a setting event and `status_rd` fall in the same cycle, the interrupt ends up set.
- R7: Results are evaluated only in cycles with `result_valid`=1 and `int_en`=1. While `int_en`=0 the event run is held at zero and the interrupt cannot set.
- R8: The previous-result register loads the selected channel on every `result_valid`, whatever `int_en` is. The first result after reset, and the first result after `var_mode` changes, cannot give a variance event.
- R9: `int_pull` (1 = drive the pin low) equals `int_flag` in every cycle.
- R10: After reset `int_flag`=0 and `int_pull`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| result_valid | input | 1 | One-cycle strobe: a new set of results is present |
| ir_res | input | 20 | Infrared channel result |
| grn_res | input | 20 | Green channel result |
| red_res | input | 20 | Red channel result |
| blu_res | input | 20 | Blue channel result |
| int_en | input | 1 | Interrupt evaluation enable |
| var_mode | input | 1 | 0 = window rule, 1 = variance rule |
| src_sel | input | 2 | Channel select |
| persist | input | 4 | Number of consecutive events required, minus one |
| thr_hi | input | 20 | Upper bound of the window |
| thr_lo | input | 20 | Lower bound of the window |
| var_code | input | 3 | Variance step code |
| status_rd | input | 1 | Status-read strobe, clears the interrupt |
| int_flag | output | 1 | Sticky interrupt status |
| int_pull | output | 1 | Pin output-enable, 1 pulls the line low |

## Verification
The status read that clears the flag can land in the same cycle as a result that completes the persistence run. The bench forces this case with directed steps that pulse `status_rd` together with an out-of-window `result_valid`, and the random phase makes the coincidence often. The rule is that setting takes priority, so the flag must read 1 afterwards. A second overlap is a `var_mode` change in the same cycle as a new result: that result must only load the previous value and raise nothing.

// File: rtl/lsint_gen.sv
module lsint_gen #(
  parameter int DW    = 20,
  parameter int PW    = 4,
  parameter int VW    = 3,
  parameter int VBASE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          result_valid,
  input  logic [DW-1:0] ir_res,
  input  logic [DW-1:0] grn_res,
  input  logic [DW-1:0] red_res,
  input  logic [DW-1:0] blu_res,
  input  logic          int_en,
  input  logic          var_mode,
  input  logic [1:0]    src_sel,
  input  logic [PW-1:0] persist,
  input  logic [DW-1:0] thr_hi,
  input  logic [DW-1:0] thr_lo,
  input  logic [VW-1:0] var_code,
  input  logic          status_rd,
  output logic          int_flag,
  output logic          int_pull
);

  logic [DW-1:0] sel, prev_q, diff, var_thr;
  logic [PW-1:0] cnt_q;
  logic          prev_ok, mode_q, mode_chg, win_evt, var_evt, evt, hit;

  always_comb begin
    case (src_sel)
      2'b00:   sel = ir_res;
      2'b01:   sel = grn_res;
      2'b10:   sel = red_res;
      default: sel = blu_res;
    endcase
  end

  assign diff     = (sel >= prev_q) ? sel - prev_q : prev_q - sel;
  assign var_thr  = DW'(VBASE) << var_code;
  assign mode_chg = var_mode != mode_q;
  assign win_evt  = (sel > thr_hi) || (sel < thr_lo);
  assign var_evt  = prev_ok && !mode_chg && (diff > var_thr);
  assign evt      = var_mode ? var_evt : win_evt;
  assign hit      = result_valid && int_en && evt && (cnt_q >= persist);
  assign int_pull = int_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      prev_ok  <= 1'b0;
      mode_q   <= 1'b0;
      cnt_q    <= '0;
      int_flag <= 1'b0;
    end else begin
      mode_q <= var_mode;
      if (result_valid) begin
        prev_q  <= sel;
        prev_ok <= 1'b1;
      end else if (mode_chg) begin
        prev_ok <= 1'b0;
      end
      if (!int_en)
        cnt_q <= '0;
      else if (result_valid)
        cnt_q <= !evt ? '0 : (cnt_q >= persist) ? cnt_q : cnt_q + 1'b1;
      if (hit)
        int_flag <= 1'b1;
      else if (status_rd)
        int_flag <= 1'b0;
    end
  end

endmodule

module lsint_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        result_valid,
  input logic        int_en,
  input logic        var_mode,
  input logic [1:0]  src_sel,
  input logic [3:0]  persist,
  input logic [19:0] grn_res,
  input logic [19:0] thr_hi,
  input logic        status_rd,
  input logic        int_flag,
  input logic        int_pull
);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_flag && !status_rd |=> int_flag);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd && !result_valid |=> !int_flag);
  p_no_eval_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(result_valid && int_en) && !int_flag |=> !int_flag);
  p_rise_needs_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_flag) |-> $past(result_valid && int_en));
  p_above_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid && int_en && !var_mode && persist == 4'd0 &&
    src_sel == 2'b01 && grn_res > thr_hi |=> int_flag);
  p_read_vs_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd && result_valid && int_en && !var_mode && persist == 4'd0 &&
    src_sel == 2'b01 && grn_res > thr_hi |=> int_flag);
  p_pin_r9: assert property (@(negedge clk) disable iff (!rst_n)
    int_pull == int_flag);
endmodule

bind lsint_gen lsint_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .result_valid(result_valid), .int_en(int_en),
  .var_mode(var_mode), .src_sel(src_sel), .persist(persist), .grn_res(grn_res),
  .thr_hi(thr_hi), .status_rd(status_rd), .int_flag(int_flag), .int_pull(int_pull)
);

// File: tb/lsint_gen_bench.sv
`timescale 1ns/1ps
module lsint_gen_bench;
  logic        clk = 0, rst_n = 0, result_valid = 0, int_en = 1, var_mode = 0, status_rd = 0;
  logic [19:0] ir_res = 20'h100, grn_res = 20'h100, red_res = 20'h100, blu_res = 20'h100;
  logic [19:0] thr_hi = 20'h0FFFFF, thr_lo = 20'h0;
  logic [1:0]  src_sel = 2'b01;
  logic [3:0]  persist = 0;
  logic [2:0]  var_code = 0;
  logic        int_flag, int_pull;
  int checks = 0, errors = 0;
  bit  done = 0;

  logic [19:0] m_prev = 0;
  bit          m_prev_ok = 0, m_mode = 0, m_flag = 0;
  int          m_run = 0;

  always #2.5 clk = ~clk;

  lsint_gen u_lsint_gen (
    .clk(clk), .rst_n(rst_n), .result_valid(result_valid), .ir_res(ir_res),
    .grn_res(grn_res), .red_res(red_res), .blu_res(blu_res), .int_en(int_en),
    .var_mode(var_mode), .src_sel(src_sel), .persist(persist), .thr_hi(thr_hi),
    .thr_lo(thr_lo), .var_code(var_code), .status_rd(status_rd),
    .int_flag(int_flag), .int_pull(int_pull)
  );

  function automatic logic [19:0] pick();
    case (src_sel)
      2'b00: return ir_res;
      2'b01: return grn_res;
      2'b10: return red_res;
      default: return blu_res;
    endcase
  endfunction

  function automatic bit is_event(logic [19:0] v);
    int d;
    if (!var_mode) return (v > thr_hi) || (v < thr_lo);
    if (!m_prev_ok || var_mode != m_mode) return 0;
    d = (v >= m_prev) ? int'(v - m_prev) : int'(m_prev - v);
    return d > (8 << var_code);
  endfunction

  task automatic check(input string tag, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input bit rd, input string tag);
    logic [19:0] s;
    bit e, fire;
    result_valid = v; status_rd = rd;
    @(posedge clk);
    s = pick();
    e = is_event(s);
    fire = v && int_en && e && (m_run >= int'(persist));
    if (!int_en) m_run = 0;
    else if (v) m_run = !e ? 0 : (m_run >= int'(persist)) ? m_run : m_run + 1;
    if (fire) m_flag = 1; else if (rd) m_flag = 0;
    if (v) begin m_prev = s; m_prev_ok = 1; end
    else if (var_mode != m_mode) m_prev_ok = 0;
    m_mode = var_mode;
    @(negedge clk);
    result_valid = 0; status_rd = 0;
    check(tag, int_flag, m_flag);
    check("R9", int_pull, m_flag);
  endtask

  task automatic setall(input logic [19:0] v);
    ir_res = v; grn_res = v; red_res = v; blu_res = v;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", int_flag, 0);
    check("R10", int_pull, 0);
    rst_n = 1;
    @(negedge clk);
    // R2 window
    thr_hi = 1000; thr_lo = 100; setall(500);
    grn_res = 1000; step(1, 0, "R2");
    grn_res = 100;  step(1, 0, "R2");
    grn_res = 1001; step(1, 0, "R2");
    check("R2", int_flag, 1);
    step(0, 0, "R5"); step(0, 0, "R5");
    step(0, 1, "R5");
    check("R5", int_flag, 0);
    grn_res = 99; step(1, 0, "R2");
    step(0, 1, "R5");
    // R1 channel select
    for (int c = 0; c < 4; c++) begin
      src_sel = c[1:0]; setall(500);
      case (c)
        0: ir_res = 2000;
        1: grn_res = 2000;
        2: red_res = 2000;
        default: blu_res = 2000;
      endcase
      step(1, 0, "R1");
      check("R1", int_flag, 1);
      step(0, 1, "R1");
      src_sel = c[1:0] + 2'd1; step(1, 0, "R1");
    end
    // R4 persistence
    src_sel = 2'b01; setall(500); persist = 2;
    grn_res = 2000; step(1, 0, "R4"); step(1, 0, "R4");
    grn_res = 500;  step(1, 0, "R4");
    grn_res = 2000; step(1, 0, "R4"); step(1, 0, "R4");
    check("R4", int_flag, 0);
    step(1, 0, "R4");
    check("R4", int_flag, 1);
    step(0, 1, "R4"); step(1, 0, "R4");
    // R6 set vs read
    step(1, 1, "R6");
    check("R6", int_flag, 1);
    persist = 0; step(0, 1, "R6");
    // R7 disable
    int_en = 0; step(1, 0, "R7"); step(1, 0, "R7");
    check("R7", int_flag, 0);
    int_en = 1; step(0, 0, "R7"); step(0, 0, "R7");
    check("R7", int_flag, 0);
    // R8 / R3 variance
    grn_res = 0; var_mode = 1; step(1, 0, "R8");
    check("R8", int_flag, 0);
    grn_res = 8; step(1, 0, "R3");
    check("R3", int_flag, 0);
    grn_res = 17; step(1, 0, "R3");
    check("R3", int_flag, 1);
    step(0, 1, "R3");
    var_code = 3; grn_res = 81; step(1, 0, "R3");
    check("R3", int_flag, 0);
    grn_res = 16; step(1, 0, "R3");
    check("R3", int_flag, 1);
    step(0, 1, "R3");
    var_code = 7; grn_res = 1041; step(1, 0, "R3");
    step(0, 1, "R3");
    int_en = 0; grn_res = 5000; step(1, 0, "R8");
    int_en = 1; grn_res = 5000; step(1, 0, "R8");
    check("R8", int_flag, 0);
    var_mode = 0; step(0, 0, "R8"); var_mode = 1; grn_res = 0; step(1, 0, "R8");
    check("R8", int_flag, 0);
    // random
    void'($urandom(32'd7321));
    for (int i = 0; i < 3000; i++) begin
      if (i % 25 == 0) begin
        int_en   = ($urandom % 8) != 0;
        var_mode = $urandom % 2;
        src_sel  = $urandom % 4;
        persist  = $urandom % 4;
        var_code = $urandom % 8;
        thr_lo   = $urandom % 600;
        thr_hi   = thr_lo + $urandom % 800;
      end
      ir_res  = $urandom % 2048; grn_res = $urandom % 2048;
      red_res = $urandom % 2048; blu_res = $urandom % 2048;
      step(($urandom % 3) != 0, ($urandom % 6) == 0, "R4");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule